// File: doc/BRIEF.md
# I2C Byte Master with Register Control

This block is a single-master I2C controller that a host steers through three small registers. A host loads the address byte into the data register, then sets the run bit in the control register. The block issues a START and shifts the address out MSB first. It takes the acknowledge slot and then parks with SCL low, raising a transfer-end flag. Bit 0 of the address byte selects the direction of every later byte in the transfer: 1 means the master reads, 0 means it writes.

While the engine is parked and the flag has been cleared, a host write to the data register launches the next byte. In write mode that byte is the value written. In read mode the master releases SDA, collects eight bits into the data register and answers in the acknowledge slot according to an acknowledge-enable bit. Clearing the run bit ends the transfer with a STOP once the current byte has finished.

The SCL rate comes from a 4-bit clock-select value that divides a base tick. The base tick is the system clock divided by `TICK_DIV`, which would be set so that it runs at 384 kHz.

Top module: `i2cm_byte_ctrl`

Register map (`reg_addr`): 0 = control, 1 = data, 2 = clock select (bits 3:0). Control bits: 0 = transfer-end flag, 1 = interrupt enable, 2 = acknowledge enable, 3 = run, 7 = slave-acknowledged status (read-only). Reads return the addressed register combinationally.

## Requirements
- R1: After reset, SCL and SDA are released (1), `irq` is 0, and the control, data and clock-select registers read 0.
- R2: Writing control with run (bit 3) = 1 while idle makes SDA fall while SCL is high, then SCL fall. The data register is then sent MSB first, 8 bits. Outside START and STOP, SDA changes only while SCL is low.
- R3: Each SCL half period, high or low, lasts (CS+1)·`TICK_DIV` clock cycles, giving a full period of 2·(CS+1)·`TICK_DIV` cycles.
- R4: In the acknowledge slot of an address or write byte, the master releases SDA. Control bit 7 then reads 1 if the slave held SDA low in that slot and 0 otherwise.
- R5: In a read byte, the master releases SDA for the 8 data bits and stores them MSB first in the data register. In the acknowledge slot it drives SDA low when control bit 2 is 1, and releases SDA when that bit is 0.
- R6: The transfer-end flag (control bit 0) sets at the end of the acknowledge slot of every byte.
- R7: Writing 0 to control bit 0 clears the flag. Writing 1 to it leaves the flag unchanged.
- R8: `irq` is 1 exactly when the interrupt enable (control bit 1) and the flag are both 1.
- R9: A data-register write while parked with the flag clear starts the next byte. While the flag is set, a data write is ignored: no SCL activity, the data register keeps its value, and no flag event is lost.
- R10: With run cleared, the block finishes any byte in progress. It then drives SDA low while SCL is low, raises SCL, raises SDA while SCL is high, and returns to idle.
- R11: Writing run = 1 while a transfer is active produces no new START and no SCL activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Transfer-end interrupt request |
| scl_o | output | 1 | SCL level driven (1 = released) |
| sda_o | output | 1 | SDA level driven (1 = released) |
| sda_i | input | 1 | Sensed SDA bus level |

## Verification
Several properties are checked on every cycle. SDA must hold steady while SCL is high outside START and STOP. The engine may only move between active bus states on a half-period boundary, and the half timer must restart from zero. A START may only be entered from idle and a STOP only from the parked state with run cleared. The flag must set after every byte, and a byte may never end while the flag is still pending. Other behaviour can only be shown by the bench's scenarios. This covers the bit order and values on the wire, the measured SCL period for two clock-select values, and the acknowledge answer chosen by the enable bit. It also covers the captured read data, the ignored data write and restart, and the STOP that follows a byte already in flight.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ST_A, S_ST_B, S_B_LO, S_B_HI, S_A_LO, S_A_HI,
    S_HOLD, S_SP_A, S_SP_B, S_SP_C
  } eng_state_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_CLK  = 2'd2;

  localparam int CB_FLAG = 0;
  localparam int CB_IE   = 1;
  localparam int CB_ACK  = 2;
  localparam int CB_RUN  = 3;
  localparam int CB_SACK = 7;
endpackage

// File: rtl/i2cm_half_timer.sv
`timescale 1ns/1ps
module i2cm_half_timer #(
  parameter int TICK_DIV = 4,
  parameter int CS_W     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CS_W-1:0] cs,
  output logic            half_end
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0]   pcnt_q, pcnt_d;
  logic [CS_W-1:0] hcnt_q, hcnt_d;
  logic            base_tick;

  always_comb begin
    base_tick = (pcnt_q == P_LAST);
    half_end  = en && base_tick && (hcnt_q >= cs);
    pcnt_d    = pcnt_q;
    hcnt_d    = hcnt_q;
    if (!en) begin
      pcnt_d = '0;
      hcnt_d = '0;
    end else begin
      pcnt_d = base_tick ? '0 : pcnt_q + PW'(1);
      if (half_end)       hcnt_d = '0;
      else if (base_tick) hcnt_d = hcnt_q + CS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      hcnt_q <= hcnt_d;
    end
  end

  // R3: every enabled stretch starts from a fresh half period
  assert_timer_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |-> (pcnt_q == '0 && hcnt_q == '0));
endmodule

// File: rtl/i2cm_byte_engine.sv
`timescale 1ns/1ps
module i2cm_byte_engine
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          go,
  input  logic          run,
  input  logic [DW-1:0] tx_byte,
  input  logic          ack_en,
  input  logic          half_end,
  input  logic          sda_in,
  output logic          timer_en,
  output logic          busy,
  output logic          holding,
  output logic          byte_done,
  output logic          rx_mode,
  output logic [DW-1:0] rx_byte,
  output logic          slave_ack,
  output logic          scl,
  output logic          sda
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] B_LAST = BW'(DW - 1);

  eng_state_e    state_q, state_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          addr_q, addr_d;
  logic          rd_q, rd_d;
  logic          sack_q, sack_d;
  logic          sda_q, sda_d;

  assign rx_mode   = rd_q & ~addr_q;
  assign busy      = (state_q != S_IDLE);
  assign holding   = (state_q == S_HOLD);
  assign timer_en  = busy && !holding;
  assign byte_done = half_end && (state_q == S_A_HI);
  assign rx_byte   = sh_q;
  assign slave_ack = sack_q;
  assign sda       = sda_q;
  assign scl       = (state_q inside {S_IDLE, S_ST_A, S_B_HI, S_A_HI, S_SP_B, S_SP_C});

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    addr_d  = addr_q;
    rd_d    = rd_q;
    sack_d  = sack_q;
    sda_d   = sda_q;
    case (state_q)
      S_IDLE: if (start) begin
        state_d = S_ST_A;
        sh_d    = tx_byte;
        bit_d   = B_LAST;
        addr_d  = 1'b1;
        rd_d    = tx_byte[0];
      end
      S_ST_A: if (half_end) state_d = S_ST_B;
      S_ST_B: if (half_end) state_d = S_B_LO;
      S_B_LO: if (half_end) state_d = S_B_HI;
      S_B_HI: if (half_end) begin
        sh_d = {sh_q[DW-2:0], sda_in};
        if (bit_q == '0) state_d = S_A_LO;
        else begin
          bit_d   = bit_q - BW'(1);
          state_d = S_B_LO;
        end
      end
      S_A_LO: if (half_end) state_d = S_A_HI;
      S_A_HI: if (half_end) begin
        state_d = S_HOLD;
        if (!rx_mode) sack_d = ~sda_in;
      end
      S_HOLD: begin
        if (!run) state_d = S_SP_A;
        else if (go) begin
          state_d = S_B_LO;
          sh_d    = tx_byte;
          bit_d   = B_LAST;
          addr_d  = 1'b0;
        end
      end
      S_SP_A: if (half_end) state_d = S_SP_B;
      S_SP_B: if (half_end) state_d = S_SP_C;
      S_SP_C: if (half_end) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    // SDA moves only while SCL is low, or inside START/STOP phases
    case (state_q)
      S_IDLE, S_SP_C: sda_d = 1'b1;
      S_ST_A, S_SP_A: sda_d = 1'b0;
      S_B_LO:         sda_d = rx_mode | sh_q[DW-1];
      S_A_LO:         sda_d = rx_mode ? ~ack_en : 1'b1;
      default:        sda_d = sda_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      addr_q  <= 1'b0;
      rd_q    <= 1'b0;
      sack_q  <= 1'b0;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      sack_q  <= sack_d;
      sda_q   <= sda_d;
    end
  end

  // R2: data line steady while clock high, outside START/STOP
  assert_sda_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl) && scl && !($past(state_q) inside {S_ST_A, S_SP_C, S_IDLE}))
      |-> $stable(sda_q));
  // R3: active bus states advance only on a half-period boundary
  assert_step_on_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q) && !($past(state_q) inside {S_IDLE, S_HOLD}))
      |-> $past(half_end));
  // R11: START phase is entered from idle only
  assert_start_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ST_A && $past(state_q) != S_ST_A) |-> $past(state_q) == S_IDLE);
  // R10: STOP begins only from the parked state with run cleared
  assert_stop_from_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SP_A && $past(state_q) != S_SP_A)
      |-> ($past(state_q) == S_HOLD && !$past(run)));
endmodule

// File: rtl/i2cm_regs.sv
`timescale 1ns/1ps
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int CS_W = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            eng_busy,
  input  logic            eng_holding,
  input  logic            byte_done,
  input  logic            rx_mode,
  input  logic [DW-1:0]   rx_byte,
  input  logic            slave_ack,
  output logic            irq,
  output logic            start,
  output logic            go,
  output logic            run,
  output logic            ack_en,
  output logic [DW-1:0]   tx_byte,
  output logic [CS_W-1:0] cs
);
  logic            run_q, run_d, ie_q, ie_d, ack_q, ack_d, flag_q, flag_d;
  logic [DW-1:0]   data_q, data_d;
  logic [CS_W-1:0] cs_q, cs_d;
  logic            ctrl_wr, data_wr, clk_wr, data_ok;

  always_comb begin
    ctrl_wr = we && (addr == A_CTRL);
    data_wr = we && (addr == A_DATA);
    clk_wr  = we && (addr == A_CLK);
    data_ok = data_wr && (!eng_busy || (eng_holding && !flag_q));
    start   = ctrl_wr && wdata[CB_RUN] && !eng_busy;
    go      = data_wr && eng_holding && !flag_q && run_q;
    tx_byte = data_ok ? wdata : data_q;

    run_d  = ctrl_wr ? wdata[CB_RUN] : run_q;
    ie_d   = ctrl_wr ? wdata[CB_IE]  : ie_q;
    ack_d  = ctrl_wr ? wdata[CB_ACK] : ack_q;
    cs_d   = clk_wr  ? wdata[CS_W-1:0] : cs_q;
    flag_d = flag_q;
    if (byte_done)                        flag_d = 1'b1;
    else if (ctrl_wr && !wdata[CB_FLAG])  flag_d = 1'b0;
    data_d = data_q;
    if (byte_done && rx_mode) data_d = rx_byte;
    else if (data_ok)         data_d = wdata;

    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CB_FLAG] = flag_q;
        rdata[CB_IE]   = ie_q;
        rdata[CB_ACK]  = ack_q;
        rdata[CB_RUN]  = run_q;
        rdata[CB_SACK] = slave_ack;
      end
      A_DATA:  rdata = data_q;
      A_CLK:   rdata = DW'(cs_q);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      ack_q  <= 1'b0;
      flag_q <= 1'b0;
      data_q <= '0;
      cs_q   <= '0;
    end else begin
      run_q  <= run_d;
      ie_q   <= ie_d;
      ack_q  <= ack_d;
      flag_q <= flag_d;
      data_q <= data_d;
      cs_q   <= cs_d;
    end
  end

  assign irq    = ie_q & flag_q;
  assign run    = run_q;
  assign ack_en = ack_q;
  assign cs     = cs_q;

  // R6: every finished byte leaves the flag raised
  assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> flag_q);
  // R9: a byte never ends while the previous event is still pending
  assert_no_lost_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !flag_q);
  // R7: writing 1 to the flag cannot raise it
  assert_w1_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CB_FLAG] && !flag_q && !byte_done) |=> !flag_q);
endmodule

// File: rtl/i2cm_byte_ctrl.sv
`timescale 1ns/1ps
module i2cm_byte_ctrl
  import i2cm_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int CS_W     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam int DW = 8;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            start, go, run, ack_en, half_end, timer_en;
  logic            busy, holding, byte_done, rx_mode, slave_ack;
  logic [DW-1:0]   tx_byte, rx_byte;
  logic [CS_W-1:0] cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2cm_half_timer #(.TICK_DIV(TICK_DIV), .CS_W(CS_W)) timer_i (
    .clk(clk), .rst_n(rst_int_n), .en(timer_en), .cs(cs), .half_end(half_end)
  );

  i2cm_byte_engine #(.DW(DW)) engine_i (
    .clk(clk), .rst_n(rst_int_n), .start(start), .go(go), .run(run),
    .tx_byte(tx_byte), .ack_en(ack_en), .half_end(half_end), .sda_in(sda_i),
    .timer_en(timer_en), .busy(busy), .holding(holding), .byte_done(byte_done),
    .rx_mode(rx_mode), .rx_byte(rx_byte), .slave_ack(slave_ack),
    .scl(scl_o), .sda(sda_o)
  );

  i2cm_regs #(.CS_W(CS_W), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .eng_busy(busy),
    .eng_holding(holding), .byte_done(byte_done), .rx_mode(rx_mode),
    .rx_byte(rx_byte), .slave_ack(slave_ack), .irq(irq), .start(start),
    .go(go), .run(run), .ack_en(ack_en), .tx_byte(tx_byte), .cs(cs)
  );
endmodule

// File: tb/i2cm_byte_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2cm_byte_ctrl_tb_top;
  localparam int TD = 4;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq, scl_o, sda_o;
  logic       slv_sda;
  logic       sda_bus;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_o & slv_sda;

  i2cm_byte_ctrl #(.TICK_DIV(TD), .CS_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_bus)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // count SCL high samples over a window of clocks
  task automatic scl_high_count(input int ncyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (scl_o) cnt++;
    end
  endtask

  // one byte on the bus; slave drives slv_byte and its ack answer
  task automatic xfer(input bit from_hold, input logic [7:0] trig,
                      input logic [7:0] slv_byte, input bit slv_ack,
                      output logic [7:0] seen, output logic seen_ack,
                      output int period);
    time t1;
    slv_sda = 1'b1;
    t1 = 0;
    period = 0;
    if (!from_hold) begin
      reg_wr(2'd0, trig);
      @(negedge scl_o);
    end else begin
      slv_sda = slv_byte[7];
      reg_wr(2'd1, trig);
    end
    for (int i = 0; i < 9; i++) begin
      slv_sda = (i < 8) ? slv_byte[7-i] : !slv_ack;
      @(posedge scl_o);
      if (i == 1) t1 = $time;
      if (i == 2) period = int'($time - t1);
      if (i < 8) seen[7-i] = sda_o;
      else       seen_ack = sda_o;
      @(negedge scl_o);
    end
    slv_sda = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 scl idle", int'(scl_o), 1);
    chk("R1 sda idle", int'(sda_o), 1);
    chk("R1 irq low", int'(irq), 0);
    reg_rd(2'd0, v); chk("R1 ctrl", int'(v), 0);
    reg_rd(2'd1, v); chk("R1 data", int'(v), 0);
    reg_rd(2'd2, v); chk("R1 clksel", int'(v), 0);
    reg_wr(2'd0, 8'h01);
    reg_rd(2'd0, v); chk("R7 write 1 keeps clear flag", int'(v), 0);
  endtask

  task automatic t_write_txn;
    logic [7:0] v, seen;
    logic       ack;
    int         per, cnt;
    reg_wr(2'd2, 8'h01);
    reg_wr(2'd1, 8'hA4);
    xfer(1'b0, 8'h0A, 8'hFF, 1'b1, seen, ack, per);
    chk("R2 address bits", int'(seen), 'hA4);
    chk("R4 ack slot released", int'(ack), 1);
    chk("R3 period cs=1", per, 2 * 2 * TD * CLK_NS);
    @(negedge clk);
    reg_rd(2'd0, v); chk("R6 R4 ctrl after addr", int'(v), 'h8B);
    chk("R8 irq on", int'(irq), 1);
    reg_wr(2'd0, 8'h09);
    reg_rd(2'd0, v); chk("R7 write 1 keeps flag", int'(v), 'h89);
    chk("R8 irq off with ie 0", int'(irq), 0);
    scl_high_count(60, cnt); chk("R11 no restart", cnt, 0);
    reg_wr(2'd1, 8'h3C);
    scl_high_count(60, cnt); chk("R9 no byte while flag set", cnt, 0);
    reg_rd(2'd1, v); chk("R9 data kept", int'(v), 'hA4);
    reg_wr(2'd0, 8'h08);
    reg_rd(2'd0, v); chk("R7 flag cleared", int'(v), 'h88);
    xfer(1'b1, 8'h3C, 8'hFF, 1'b0, seen, ack, per);
    chk("R9 data byte sent", int'(seen), 'h3C);
    @(negedge clk);
    reg_rd(2'd0, v); chk("R4 R6 nack status", int'(v), 'h09);
    reg_wr(2'd0, 8'h00);
    @(posedge scl_o); #1 chk("R10 sda low as scl rises", int'(sda_o), 0);
    @(posedge sda_o); #1 chk("R10 scl high as sda rises", int'(scl_o), 1);
    repeat (20) @(negedge clk);
    chk("R10 idle lines", int'({scl_o, sda_o}), 3);
  endtask

  task automatic t_read_txn;
    logic [7:0] v, seen;
    logic       ack;
    int         per;
    reg_wr(2'd2, 8'h03);
    reg_wr(2'd1, 8'h91);
    xfer(1'b0, 8'h0C, 8'hFF, 1'b1, seen, ack, per);
    chk("R2 read address", int'(seen), 'h91);
    @(negedge clk);
    reg_rd(2'd0, v); chk("R6 ctrl after read addr", int'(v), 'h8D);
    chk("R8 irq off ie 0", int'(irq), 0);
    reg_wr(2'd0, 8'h0C);
    xfer(1'b1, 8'h00, 8'h5A, 1'b0, seen, ack, per);
    chk("R5 released during rx", int'(seen), 'hFF);
    chk("R5 ack driven", int'(ack), 0);
    chk("R3 period cs=3", per, 2 * 4 * TD * CLK_NS);
    @(negedge clk);
    reg_rd(2'd1, v); chk("R5 rx data", int'(v), 'h5A);
    reg_wr(2'd0, 8'h08);
    xfer(1'b1, 8'h00, 8'hC3, 1'b0, seen, ack, per);
    chk("R5 nack released", int'(ack), 1);
    @(negedge clk);
    reg_rd(2'd1, v); chk("R5 rx data 2", int'(v), 'hC3);
    reg_wr(2'd0, 8'h00);
    repeat (300) @(negedge clk);
    chk("R10 idle after read", int'({scl_o, sda_o}), 3);
  endtask

  task automatic t_stop_midbyte;
    logic [7:0] v;
    int         rises;
    logic       prev;
    reg_wr(2'd2, 8'h00);
    reg_wr(2'd1, 8'hF0);
    reg_wr(2'd0, 8'h08);
    reg_wr(2'd0, 8'h00);
    rises = 0;
    prev = scl_o;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (scl_o && !prev) rises++;
      prev = scl_o;
    end
    chk("R10 byte completes then stop", rises, 10);
    reg_rd(2'd0, v); chk("R10 R6 flag after midbyte stop", int'(v), 'h01);
    chk("R10 idle lines", int'({scl_o, sda_o}), 3);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00; slv_sda = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_txn();
    t_read_txn();
    t_stop_midbyte();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule